// File: doc/BRIEF.md
# Counted-Loop Branch Controller

This block performs the control step of a decrement-and-branch loop instruction. When the execute strobe is raised, it tests a 4-bit condition selector against the processor flags. If the condition holds, the loop terminates. Execution falls through to the following instruction and the counter register is left untouched.

If the condition does not hold, the block decrements the low half of the counter register. The upper half is kept unchanged. The block then chooses between leaving the loop and jumping back by a signed byte displacement.

The controller sits in the execute stage between the register file and the fetch unit. The register file supplies the counter value and accepts the write-back when the write enable pulses. The fetch unit takes the next program counter and the branch indication one cycle after the strobe.

Top module: `dbl_loop_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is zero at the next edge. Reset is synchronous.
- R2: The results for a strobe sampled at edge k appear on the outputs after edge k. When `exec_i` is low at an edge, `count_we_o` and `taken_o` are low after that edge, and `next_pc_o` and `count_o` keep their values.
- R3: The flags are encoded as `flags_i` = {N, Z, V, C}, with bit 3 = N and bit 0 = C. The condition codes decode as follows:
  - 0 is always true and 1 is always false.
  - 2 is !C&!Z and 3 is C|Z.
  - 4 is !C and 5 is C.
  - 6 is !Z and 7 is Z.
  - 8 is !V and 9 is V.
  - 10 is !N and 11 is N.
  - 12 is N==V and 13 is N!=V.
  - 14 is !Z&(N==V) and 15 is Z|(N!=V).
- R4: When the condition is true, `count_we_o` and `taken_o` are 0, `count_o` equals the presented counter, and `next_pc_o` is `inst_addr_i` + 4.
- R5: When the condition is false, `count_we_o` is 1. `count_o[15:0]` is the low 16 bits of the counter minus 1, modulo 2^16. `count_o[31:16]` equals the upper 16 bits of the presented counter.
- R6: When the condition is false and the decremented low half is 0xFFFF (which includes a low half of 0 wrapping), `taken_o` is 0 and `next_pc_o` is `inst_addr_i` + 4.
- R7: When the condition is false and the decremented low half is not 0xFFFF, `taken_o` is 1. `next_pc_o` is `inst_addr_i` + 2 plus the sign-extended displacement, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| exec_i | input | 1 | Execute strobe for one loop step |
| inst_addr_i | input | 32 | Address of the loop instruction's opcode word |
| disp_i | input | 16 | Signed byte displacement |
| cond_i | input | 4 | Condition selector |
| flags_i | input | 4 | Flags {N, Z, V, C} |
| count_i | input | 32 | Current counter register value |
| next_pc_o | output | 32 | Next program counter |
| count_o | output | 32 | Counter value to write back |
| count_we_o | output | 1 | Counter write enable, one-cycle pulse |
| taken_o | output | 1 | Branch taken, one-cycle pulse |

## Verification
The bound checker watches the following on every cycle:
- the one-cycle pulse timing of the write enable and taken outputs, and that the outputs hold between strobes;
- preservation of the counter's upper half, and the decrement of its low half whenever a write occurs;
- that taken agrees with a non-0xFFFF result;
- both next-PC formulas;
- the behaviour of the two fixed condition codes.

Only the bench's scenarios cover the rest:
- the full 16-by-16 condition-versus-flag decode;
- the wrap of a zero counter;
- backward branches and a branch whose target wraps the address space.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

    // Bit positions of the flags inside flags_i
    localparam int FLG_C = 0;
    localparam int FLG_V = 1;
    localparam int FLG_Z = 2;
    localparam int FLG_N = 3;
    localparam int FLG_W = 4;

    localparam int COND_W = 4;

    typedef enum logic [COND_W-1:0] {
        CC_TRUE  = 4'h0,
        CC_FALSE = 4'h1,
        CC_HI    = 4'h2,
        CC_LS    = 4'h3,
        CC_CC    = 4'h4,
        CC_CS    = 4'h5,
        CC_NE    = 4'h6,
        CC_EQ    = 4'h7,
        CC_VC    = 4'h8,
        CC_VS    = 4'h9,
        CC_PL    = 4'hA,
        CC_MI    = 4'hB,
        CC_GE    = 4'hC,
        CC_LT    = 4'hD,
        CC_GT    = 4'hE,
        CC_LE    = 4'hF
    } cond_e;

endpackage

// File: rtl/dbl_cond_eval.sv
module dbl_cond_eval
    import dbl_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  logic [FLG_W-1:0]  flags_i,
    output logic              hit_o
);

    logic fn, fz, fv, fc;
    logic sgn_ok;
    cond_e sel;

    always_comb begin
        fn     = flags_i[FLG_N];
        fz     = flags_i[FLG_Z];
        fv     = flags_i[FLG_V];
        fc     = flags_i[FLG_C];
        sgn_ok = ~(fn ^ fv);
        sel    = cond_e'(cond_i);
        unique case (sel)
            CC_TRUE:  hit_o = 1'b1;
            CC_FALSE: hit_o = 1'b0;
            CC_HI:    hit_o = ~fc & ~fz;
            CC_LS:    hit_o = fc | fz;
            CC_CC:    hit_o = ~fc;
            CC_CS:    hit_o = fc;
            CC_NE:    hit_o = ~fz;
            CC_EQ:    hit_o = fz;
            CC_VC:    hit_o = ~fv;
            CC_VS:    hit_o = fv;
            CC_PL:    hit_o = ~fn;
            CC_MI:    hit_o = fn;
            CC_GE:    hit_o = sgn_ok;
            CC_LT:    hit_o = ~sgn_ok;
            CC_GT:    hit_o = ~fz & sgn_ok;
            CC_LE:    hit_o = fz | ~sgn_ok;
            default:  hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dbl_count_step.sv
module dbl_count_step #(
    parameter int CNT_W  = 32,
    parameter int LOOP_W = 16
) (
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expired_o
);

    logic [LOOP_W-1:0] low_dec;

    assign low_dec   = count_i[LOOP_W-1:0] - LOOP_W'(1);
    assign expired_o = (low_dec == {LOOP_W{1'b1}});

    generate
        if (CNT_W > LOOP_W) begin : g_split
            assign count_o = {count_i[CNT_W-1:LOOP_W], low_dec};
        end else begin : g_whole
            assign count_o = low_dec;
        end
    endgenerate

endmodule

// File: rtl/dbl_target_gen.sv
module dbl_target_gen #(
    parameter int ADDR_W   = 32,
    parameter int DISP_W   = 16,
    parameter int WORD_BYTES = 2
) (
    input  logic [ADDR_W-1:0] inst_addr_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] fall_o,
    output logic [ADDR_W-1:0] target_o
);

    // Base for the jump is one word past the opcode; fall-through skips opcode and displacement
    localparam int BASE_OFS = WORD_BYTES;
    localparam int FALL_OFS = 2 * WORD_BYTES;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] base;

    assign disp_ext = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    assign base     = inst_addr_i + ADDR_W'(BASE_OFS);
    assign fall_o   = inst_addr_i + ADDR_W'(FALL_OFS);
    assign target_o = base + disp_ext;

endmodule

// File: rtl/dbl_loop_ctrl.sv
module dbl_loop_ctrl
    import dbl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int CNT_W  = 32,
    parameter int LOOP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_i,
    input  logic [ADDR_W-1:0] inst_addr_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [COND_W-1:0] cond_i,
    input  logic [FLG_W-1:0]  flags_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              count_we_o,
    output logic              taken_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [CNT_W-1:0]  cnt;
        logic              we;
        logic              taken;
    } res_t;

    res_t res_d, res_q;

    logic              cond_hit;
    logic [CNT_W-1:0]  cnt_step;
    logic              cnt_expired;
    logic [ADDR_W-1:0] pc_fall;
    logic [ADDR_W-1:0] pc_target;

    dbl_cond_eval u_cond (
        .cond_i  (cond_i),
        .flags_i (flags_i),
        .hit_o   (cond_hit)
    );

    dbl_count_step #(
        .CNT_W  (CNT_W),
        .LOOP_W (LOOP_W)
    ) u_step (
        .count_i   (count_i),
        .count_o   (cnt_step),
        .expired_o (cnt_expired)
    );

    dbl_target_gen #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_tgt (
        .inst_addr_i (inst_addr_i),
        .disp_i      (disp_i),
        .fall_o      (pc_fall),
        .target_o    (pc_target)
    );

    always_comb begin
        res_d       = res_q;
        res_d.we    = 1'b0;
        res_d.taken = 1'b0;
        if (exec_i) begin
            if (cond_hit) begin
                res_d.pc  = pc_fall;
                res_d.cnt = count_i;
            end else begin
                res_d.cnt = cnt_step;
                res_d.we  = 1'b1;
                if (cnt_expired) begin
                    res_d.pc = pc_fall;
                end else begin
                    res_d.pc    = pc_target;
                    res_d.taken = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign next_pc_o  = res_q.pc;
    assign count_o    = res_q.cnt;
    assign count_we_o = res_q.we;
    assign taken_o    = res_q.taken;

endmodule

// File: rtl/dbl_loop_ctrl_chk.sv
module dbl_loop_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int CNT_W  = 32,
    parameter int LOOP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              exec_i,
    input logic [ADDR_W-1:0] inst_addr_i,
    input logic [DISP_W-1:0] disp_i,
    input logic [3:0]        cond_i,
    input logic [CNT_W-1:0]  count_i,
    input logic [ADDR_W-1:0] next_pc_o,
    input logic [CNT_W-1:0]  count_o,
    input logic              count_we_o,
    input logic              taken_o
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (next_pc_o == '0 && count_o == '0 && !count_we_o && !taken_o));

    assert_idle_pulses_low_R2: assert property (@(posedge clk) disable iff (rst)
        !exec_i |=> (!count_we_o && !taken_o));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !exec_i |=> ($stable(next_pc_o) && $stable(count_o)));

    assert_always_true_no_write_R4: assert property (@(posedge clk) disable iff (rst)
        (exec_i && cond_i == 4'h0) |=> (!count_we_o && !taken_o && count_o == $past(count_i)));

    assert_always_false_writes_R5: assert property (@(posedge clk) disable iff (rst)
        (exec_i && cond_i == 4'h1) |=> count_we_o);

    assert_upper_kept_R5: assert property (@(posedge clk) disable iff (rst)
        exec_i |=> (count_o[CNT_W-1:LOOP_W] == $past(count_i[CNT_W-1:LOOP_W])));

    assert_low_decrement_R5: assert property (@(posedge clk) disable iff (rst)
        (exec_i ##1 count_we_o) |->
            (count_o[LOOP_W-1:0] == LOOP_W'($past(count_i[LOOP_W-1:0]) - 1)));

    assert_taken_rule_R6: assert property (@(posedge clk) disable iff (rst)
        exec_i |=> (taken_o == (count_we_o && count_o[LOOP_W-1:0] != {LOOP_W{1'b1}})));

    assert_fall_pc_R6: assert property (@(posedge clk) disable iff (rst)
        exec_i |=> (taken_o || next_pc_o == $past(inst_addr_i) + ADDR_W'(4)));

    assert_target_pc_R7: assert property (@(posedge clk) disable iff (rst)
        exec_i |=> (!taken_o || next_pc_o ==
            $past(inst_addr_i) + ADDR_W'(2) + {{(ADDR_W-DISP_W){$past(disp_i[DISP_W-1])}}, $past(disp_i)}));

endmodule

bind dbl_loop_ctrl dbl_loop_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .CNT_W  (CNT_W),
    .LOOP_W (LOOP_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .exec_i      (exec_i),
    .inst_addr_i (inst_addr_i),
    .disp_i      (disp_i),
    .cond_i      (cond_i),
    .count_i     (count_i),
    .next_pc_o   (next_pc_o),
    .count_o     (count_o),
    .count_we_o  (count_we_o),
    .taken_o     (taken_o)
);

// File: tb/sim_dbl_loop_ctrl.sv
module sim_dbl_loop_ctrl;

    localparam time CLK_HALF = 5ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        exec_i;
    logic [31:0] inst_addr_i;
    logic [15:0] disp_i;
    logic [3:0]  cond_i;
    logic [3:0]  flags_i;
    logic [31:0] count_i;
    logic [31:0] next_pc_o;
    logic [31:0] count_o;
    logic        count_we_o;
    logic        taken_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #CLK_HALF clk = ~clk;

    dbl_loop_ctrl u0 (
        .clk(clk), .rst(rst), .exec_i(exec_i), .inst_addr_i(inst_addr_i),
        .disp_i(disp_i), .cond_i(cond_i), .flags_i(flags_i), .count_i(count_i),
        .next_pc_o(next_pc_o), .count_o(count_o), .count_we_o(count_we_o),
        .taken_o(taken_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent decode of the condition table, flags = {N,Z,V,C}
    function automatic bit ref_cond(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], v = f[1], cy = f[0];
        bit r;
        case (c[3:1])
            3'd0: r = 1'b1;
            3'd1: r = !(cy || z);
            3'd2: r = !cy;
            3'd3: r = !z;
            3'd4: r = !v;
            3'd5: r = !n;
            3'd6: r = (n == v);
            default: r = !z && (n == v);
        endcase
        return c[0] ? !r : r;
    endfunction

    // Apply one strobe at the falling edge, return after outputs are registered
    task automatic step(input logic [31:0] a, input logic [15:0] d, input logic [3:0] c,
                        input logic [3:0] f, input logic [31:0] cnt);
        @(negedge clk);
        exec_i = 1'b1; inst_addr_i = a; disp_i = d; cond_i = c; flags_i = f; count_i = cnt;
        @(negedge clk);
        exec_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; exec_i = 1'b0; inst_addr_i = '0; disp_i = '0;
        cond_i = '0; flags_i = '0; count_i = '0;
        repeat (3) @(negedge clk);
        check("R1 pc", next_pc_o, 32'h0);
        check("R1 cnt", count_o, 32'h0);
        check("R1 we", {31'b0, count_we_o}, 32'h0);
        check("R1 taken", {31'b0, taken_o}, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_cond_table();
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                bit t = ref_cond(4'(c), 4'(f));
                step(32'h0000_2000, 16'h0010, 4'(c), 4'(f), 32'h0000_0100);
                check($sformatf("R3 cond=%0d flags=%0d we", c, f), {31'b0, count_we_o}, {31'b0, !t});
            end
        end
    endtask

    task automatic t_cond_true();
        step(32'h0000_4000, 16'h0040, 4'h7, 4'b0100, 32'h5555_0003);
        check("R4 we", {31'b0, count_we_o}, 32'h0);
        check("R4 taken", {31'b0, taken_o}, 32'h0);
        check("R4 cnt", count_o, 32'h5555_0003);
        check("R4 pc", next_pc_o, 32'h0000_4004);
    endtask

    task automatic t_decrement();
        step(32'h0000_1000, 16'h0100, 4'h1, 4'h0, 32'hABCD_0005);
        check("R5 cnt", count_o, 32'hABCD_0004);
        check("R5 we", {31'b0, count_we_o}, 32'h1);
        check("R7 taken fwd", {31'b0, taken_o}, 32'h1);
        check("R7 pc fwd", next_pc_o, 32'h0000_1102);
        step(32'h0000_1000, 16'hFFFC, 4'h6, 4'b0100, 32'hFFFF_0001);
        check("R5 cnt to zero", count_o, 32'hFFFF_0000);
        check("R7 taken back", {31'b0, taken_o}, 32'h1);
        check("R7 pc back", next_pc_o, 32'h0000_0FFE);
    endtask

    task automatic t_wrap();
        step(32'h0000_3000, 16'hFF00, 4'h1, 4'h0, 32'h1234_0000);
        check("R6 cnt", count_o, 32'h1234_FFFF);
        check("R6 we", {31'b0, count_we_o}, 32'h1);
        check("R6 taken", {31'b0, taken_o}, 32'h0);
        check("R6 pc", next_pc_o, 32'h0000_3004);
    endtask

    task automatic t_addr_wrap();
        step(32'hFFFF_FFFE, 16'h0010, 4'h1, 4'h0, 32'h0000_0009);
        check("R7 pc wrap", next_pc_o, 32'h0000_0010);
        check("R7 taken wrap", {31'b0, taken_o}, 32'h1);
    endtask

    task automatic t_idle();
        step(32'h0000_8000, 16'h0020, 4'h1, 4'h0, 32'h0000_0002);
        inst_addr_i = 32'hDEAD_BEEE; count_i = 32'h0BAD_0BAD; cond_i = 4'h1;
        repeat (3) @(negedge clk);
        check("R2 we idle", {31'b0, count_we_o}, 32'h0);
        check("R2 taken idle", {31'b0, taken_o}, 32'h0);
        check("R2 pc hold", next_pc_o, 32'h0000_8022);
        check("R2 cnt hold", count_o, 32'h0000_0001);
    endtask

    initial begin
        t_reset();
        t_cond_table();
        t_cond_true();
        t_decrement();
        t_wrap();
        t_addr_wrap();
        t_idle();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule